// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

This block sits between a host that issues 32-bit register accesses and a controller whose registers are 64 bits wide. The host sees a small window of 32-bit registers: an upper data word, a lower data word, a command register, a reset register and a status register. A single write to the command register starts one transaction towards the controller. Bit 31 of the command word picks the direction and the low bits name the 64-bit target register.

For a write, the host first fills both data words and then issues the command. The bridge presents the concatenated 64-bit value to the controller. For a read, the command alone starts the access, and the returned 64-bit value lands in the two data words, upper half in the upper word. The controller side is a level request held until a one-cycle acknowledge. A busy flag and a sticky error flag in the status register let the host follow each transaction. A write to the reset register clears the error flag and abandons any transaction still waiting.

Top module: `regbridge64`

## Requirements
- R1: Host register byte offsets are: upper data word 0x00, lower data word 0x04, command 0x08, reset 0x18, status 0x1C. A host read returns its value on `hst_rdata` with `hst_rvalid` high in the cycle after the access. Reads of any other offset, and of the command and reset registers, return zero. Writes to undecoded offsets (0x20 included) change nothing.
- R2: A command write with bit 31 = 1 and an accepted offset raises `ctl_req` in the next cycle, with `ctl_we` = 1, `ctl_offset` = command bits [CTL_OFS_W-1:0] and `ctl_wdata` = {upper word, lower word}. Completion of a write leaves both data words unchanged.
- R3: A command write with bit 31 = 0 and an accepted offset raises `ctl_req` with `ctl_we` = 0. At the acknowledge, `ctl_rdata[63:32]` is stored in the upper data word and `ctl_rdata[31:0]` in the lower one, and `ctl_req` falls in the next cycle.
- R4: Status bit 0 (busy) and `ctl_req` are high from the cycle after an accepted command until the cycle after `ctl_ack`. While the request waits, its offset, direction and write data stay stable.
- R5: A command written while busy starts nothing, leaves the request in flight untouched and sets status bit 31.
- R6: A command is refused when any of bits [30:CTL_OFS_W] is set or when bits [CTL_OFS_W-1:0] are not below NUM_TGT. A refused command sets status bit 31 and raises no request.
- R7: Status bit 31 stays set across later transactions until the host writes the reset register. That write clears busy and the error flag and drops `ctl_req`. An acknowledge arriving with it or after it changes no data word.
- R8: Host writes to either data word while busy are ignored.
- R9: An acknowledge while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_valid | input | 1 | Host access strobe, one cycle per access |
| hst_write | input | 1 | 1 = host write, 0 = host read |
| hst_addr | input | 6 | Host register byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read access |
| ctl_req | output | 1 | Request to the controller, held until acknowledged |
| ctl_we | output | 1 | 1 = write the target register, 0 = read it |
| ctl_offset | output | CTL_OFS_W | Target register offset |
| ctl_wdata | output | 64 | Write data for the target register |
| ctl_rdata | input | 64 | Read data from the controller, sampled at the acknowledge |
| ctl_ack | input | 1 | One-cycle acknowledge from the controller |

## Verification
The bench builds the bridge with CTL_OFS_W = 8 and NUM_TGT = 10. Because NUM_TGT is below 2^CTL_OFS_W, the offset check uses the magnitude-compare variant. Offsets 9 and 10 then straddle the limit, and offset 0x100 tests the high-bit check on its own. The responder's acknowledge latency is a bench variable, so commands, data writes and resets can land inside a long wait. Forced acknowledges can be issued with no request pending, and late ones after an abort.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

  localparam int HOST_AW = 6;
  localparam int HOST_DW = 32;

  localparam logic [HOST_AW-1:0] ADR_DATA_HI = 6'h00;
  localparam logic [HOST_AW-1:0] ADR_DATA_LO = 6'h04;
  localparam logic [HOST_AW-1:0] ADR_CMD     = 6'h08;
  localparam logic [HOST_AW-1:0] ADR_RESET   = 6'h18;
  localparam logic [HOST_AW-1:0] ADR_STATUS  = 6'h1C;

  localparam int CMD_DIR_BIT   = 31;
  localparam int STS_ERR_BIT   = 31;
  localparam int STS_BUSY_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DHI,
    SEL_DLO,
    SEL_CMD,
    SEL_RST,
    SEL_STS
  } hsel_e;

endpackage

// File: rtl/rb_host_decode.sv
module rb_host_decode
  import regbridge_pkg::*;
(
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [HOST_AW-1:0] addr_i,
  output hsel_e              sel_o,
  output logic               wr_stb_o,
  output logic               rd_stb_o
);

  always_comb begin
    unique case (addr_i)
      ADR_DATA_HI: sel_o = SEL_DHI;
      ADR_DATA_LO: sel_o = SEL_DLO;
      ADR_CMD:     sel_o = SEL_CMD;
      ADR_RESET:   sel_o = SEL_RST;
      ADR_STATUS:  sel_o = SEL_STS;
      default:     sel_o = SEL_NONE;
    endcase
  end

  assign wr_stb_o = valid_i & write_i;
  assign rd_stb_o = valid_i & ~write_i;

endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import regbridge_pkg::*;
#(
  parameter int CTL_OFS_W = 8,
  parameter int NUM_TGT   = 10
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 cmd_wr_i,
  input  logic [HOST_DW-1:0]   cmd_word_i,
  input  logic                 abort_i,
  input  logic                 ack_i,
  output logic                 busy_o,
  output logic                 err_o,
  output logic                 we_o,
  output logic [CTL_OFS_W-1:0] ofs_o,
  output logic                 fill_o
);

  localparam int HI_W     = CMD_DIR_BIT - CTL_OFS_W;
  localparam int SPACE    = 1 << CTL_OFS_W;

  logic                 busy_q, busy_d;
  logic                 err_q, err_d;
  logic                 we_q;
  logic [CTL_OFS_W-1:0] ofs_q;
  logic                 load_en;
  logic                 hi_clear;
  logic                 range_ok;
  logic                 ofs_ok;

  assign hi_clear = (cmd_word_i[CMD_DIR_BIT-1:CTL_OFS_W] == {HI_W{1'b0}});

  generate
    if (NUM_TGT >= SPACE) begin : g_full_space
      assign range_ok = 1'b1;
    end else begin : g_limited_space
      assign range_ok = (32'(cmd_word_i[CTL_OFS_W-1:0]) < 32'(NUM_TGT));
    end
  endgenerate

  assign ofs_ok = hi_clear & range_ok;

  always_comb begin
    busy_d  = busy_q;
    err_d   = err_q;
    load_en = 1'b0;
    fill_o  = 1'b0;
    if (abort_i) begin
      busy_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (busy_q && ack_i) begin
        busy_d = 1'b0;
        fill_o = ~we_q;
      end
      if (cmd_wr_i) begin
        if (busy_q || !ofs_ok) begin
          err_d = 1'b1;
        end else begin
          busy_d  = 1'b1;
          load_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b0;
      ofs_q <= '0;
    end else if (load_en) begin
      we_q  <= cmd_word_i[CMD_DIR_BIT];
      ofs_q <= cmd_word_i[CTL_OFS_W-1:0];
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign we_o   = we_q;
  assign ofs_o  = ofs_q;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o && !ack_i && !abort_i |=> busy_o && $stable(ofs_o) && $stable(we_o));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o && ack_i |=> !busy_o);

  // R5
  stale_cmd_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o && cmd_wr_i && !abort_i |=> err_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    err_o && !abort_i |=> err_o);

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    abort_i |=> !busy_o && !err_o);

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_o && ack_i && !cmd_wr_i |=> !busy_o);

endmodule

// File: rtl/rb_regfile.sv
module rb_regfile
  import regbridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  hsel_e              sel_i,
  input  logic               wr_stb_i,
  input  logic               rd_stb_i,
  input  logic [HOST_DW-1:0] wdata_i,
  input  logic               busy_i,
  input  logic               err_i,
  input  logic               fill_i,
  input  logic [2*HOST_DW-1:0] fill_data_i,
  output logic [HOST_DW-1:0] data_hi_o,
  output logic [HOST_DW-1:0] data_lo_o,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               rvalid_o
);

  logic [HOST_DW-1:0] hi_q, hi_d;
  logic [HOST_DW-1:0] lo_q, lo_d;
  logic [HOST_DW-1:0] rd_q, rd_d;
  logic               rv_q;
  logic [HOST_DW-1:0] status_word;
  logic               host_hi_wr;
  logic               host_lo_wr;

  assign host_hi_wr = wr_stb_i && (sel_i == SEL_DHI) && !busy_i;
  assign host_lo_wr = wr_stb_i && (sel_i == SEL_DLO) && !busy_i;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (fill_i) begin
      hi_d = fill_data_i[2*HOST_DW-1:HOST_DW];
      lo_d = fill_data_i[HOST_DW-1:0];
    end else begin
      if (host_hi_wr) hi_d = wdata_i;
      if (host_lo_wr) lo_d = wdata_i;
    end
  end

  always_comb begin
    status_word               = '0;
    status_word[STS_ERR_BIT]  = err_i;
    status_word[STS_BUSY_BIT] = busy_i;
  end

  always_comb begin
    unique case (sel_i)
      SEL_DHI: rd_d = hi_q;
      SEL_DLO: rd_d = lo_q;
      SEL_STS: rd_d = status_word;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_stb_i) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rv_q <= 1'b0;
    else         rv_q <= rd_stb_i;
  end

  assign data_hi_o = hi_q;
  assign data_lo_o = lo_q;
  assign rdata_o   = rd_q;
  assign rvalid_o  = rv_q;

  // R8
  frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_i && !fill_i |=> $stable(data_hi_o) && $stable(data_lo_o));

  // R1
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_stb_i |=> rvalid_o);

  // R1
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_stb_i |=> !rvalid_o);

  // R9
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_i && !wr_stb_i |=> $stable(data_hi_o) && $stable(data_lo_o));

endmodule

// File: rtl/regbridge64.sv
module regbridge64
  import regbridge_pkg::*;
#(
  parameter int CTL_OFS_W = 8,
  parameter int NUM_TGT   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hst_valid,
  input  logic                 hst_write,
  input  logic [5:0]           hst_addr,
  input  logic [31:0]          hst_wdata,
  output logic [31:0]          hst_rdata,
  output logic                 hst_rvalid,
  output logic                 ctl_req,
  output logic                 ctl_we,
  output logic [CTL_OFS_W-1:0] ctl_offset,
  output logic [63:0]          ctl_wdata,
  input  logic [63:0]          ctl_rdata,
  input  logic                 ctl_ack
);

  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  hsel_e              sel;
  logic               wr_stb;
  logic               rd_stb;
  logic               cmd_wr;
  logic               abort;
  logic               busy;
  logic               err;
  logic               fill;
  logic [HOST_DW-1:0] data_hi;
  logic [HOST_DW-1:0] data_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rb_host_decode u_decode (
    .valid_i  (hst_valid),
    .write_i  (hst_write),
    .addr_i   (hst_addr),
    .sel_o    (sel),
    .wr_stb_o (wr_stb),
    .rd_stb_o (rd_stb)
  );

  assign cmd_wr = wr_stb && (sel == SEL_CMD);
  assign abort  = wr_stb && (sel == SEL_RST);

  rb_sequencer #(
    .CTL_OFS_W (CTL_OFS_W),
    .NUM_TGT   (NUM_TGT)
  ) u_seq (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .cmd_wr_i   (cmd_wr),
    .cmd_word_i (hst_wdata),
    .abort_i    (abort),
    .ack_i      (ctl_ack),
    .busy_o     (busy),
    .err_o      (err),
    .we_o       (ctl_we),
    .ofs_o      (ctl_offset),
    .fill_o     (fill)
  );

  rb_regfile u_regs (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .sel_i       (sel),
    .wr_stb_i    (wr_stb),
    .rd_stb_i    (rd_stb),
    .wdata_i     (hst_wdata),
    .busy_i      (busy),
    .err_i       (err),
    .fill_i      (fill),
    .fill_data_i (ctl_rdata),
    .data_hi_o   (data_hi),
    .data_lo_o   (data_lo),
    .rdata_o     (hst_rdata),
    .rvalid_o    (hst_rvalid)
  );

  assign ctl_req   = busy;
  assign ctl_wdata = {data_hi, data_lo};

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_req && !ctl_ack && !abort |=> ctl_req && $stable(ctl_wdata));

  // R6
  no_req_on_refused_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_req && cmd_wr && !err && $past(!err) && !$past(cmd_wr) |=> ctl_req || err);

endmodule

// File: tb/regbridge64_bench.sv
`timescale 1ns/1ps
module regbridge64_bench;

  localparam int OW = 8;
  localparam int NT = 10;

  logic          clk;
  logic          rst_n;
  logic          hst_valid;
  logic          hst_write;
  logic [5:0]    hst_addr;
  logic [31:0]   hst_wdata;
  logic [31:0]   hst_rdata;
  logic          hst_rvalid;
  logic          ctl_req;
  logic          ctl_we;
  logic [OW-1:0] ctl_offset;
  logic [63:0]   ctl_wdata;
  logic [63:0]   ctl_rdata;
  logic          ctl_ack;

  int errors;
  int checks;
  int cycles;
  int ack_lat;
  int ack_cnt;
  bit auto_ack;
  bit force_ack;
  bit model_on;
  bit done;

  regbridge64 #(.CTL_OFS_W(OW), .NUM_TGT(NT)) u_regbridge64 (
    .clk, .rst_n, .hst_valid, .hst_write, .hst_addr, .hst_wdata,
    .hst_rdata, .hst_rvalid, .ctl_req, .ctl_we, .ctl_offset,
    .ctl_wdata, .ctl_rdata, .ctl_ack
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] resp(input logic [OW-1:0] o);
    return {24'hC0FFEE, o, 24'h5A5A5A, ~o};
  endfunction

  assign ctl_rdata = resp(ctl_offset);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // controller responder
  always @(negedge clk) begin
    if (force_ack) ctl_ack = 1'b1;
    else if (ctl_ack) ctl_ack = 1'b0;
    else if (auto_ack && ctl_req) begin
      if (ack_cnt >= ack_lat) begin ctl_ack = 1'b1; ack_cnt = 0; end
      else ack_cnt++;
    end else ack_cnt = 0;
  end

  // behavioural reference model
  logic          m_busy, m_err, m_we, m_rv;
  logic [OW-1:0] m_ofs;
  logic [31:0]   m_hi, m_lo, m_rd;

  function automatic bit accepted(input logic [31:0] c);
    return (c[30:OW] == 0) && (int'(c[OW-1:0]) < NT);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_err <= 0; m_we <= 0; m_rv <= 0;
      m_ofs <= '0; m_hi <= '0; m_lo <= '0; m_rd <= '0;
    end else begin
      m_rv <= 1'b0;
      if (hst_valid && !hst_write) begin
        m_rv <= 1'b1;
        case (hst_addr)
          6'h00:   m_rd <= m_hi;
          6'h04:   m_rd <= m_lo;
          6'h1C:   m_rd <= {m_err, 30'd0, m_busy};
          default: m_rd <= 32'd0;
        endcase
      end
      if (hst_valid && hst_write && hst_addr == 6'h18) begin
        m_busy <= 1'b0;
        m_err  <= 1'b0;
      end else begin
        if (m_busy && ctl_ack) begin
          m_busy <= 1'b0;
          if (!m_we) begin
            m_hi <= resp(m_ofs)[63:32];
            m_lo <= resp(m_ofs)[31:0];
          end
        end
        if (hst_valid && hst_write) begin
          case (hst_addr)
            6'h00: if (!m_busy) m_hi <= hst_wdata;
            6'h04: if (!m_busy) m_lo <= hst_wdata;
            6'h08: begin
              if (m_busy || !accepted(hst_wdata)) m_err <= 1'b1;
              else begin
                m_busy <= 1'b1;
                m_we   <= hst_wdata[31];
                m_ofs  <= hst_wdata[OW-1:0];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on && !done) begin
      check("MODEL R4 ctl_req", 64'(ctl_req), 64'(m_busy));
      if (m_busy) begin
        check("MODEL R2 ctl_we", 64'(ctl_we), 64'(m_we));
        check("MODEL R2 ctl_offset", 64'(ctl_offset), 64'(m_ofs));
        if (m_we) check("MODEL R2 ctl_wdata", ctl_wdata, {m_hi, m_lo});
      end
      check("MODEL R1 hst_rvalid", 64'(hst_rvalid), 64'(m_rv));
      if (m_rv) check("MODEL R1 hst_rdata", 64'(hst_rdata), 64'(m_rd));
    end
  end

  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_valid = 1'b0; hst_write = 1'b0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b0; hst_addr = a;
    @(negedge clk);
    hst_valid = 1'b0;
    d = hst_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && ctl_req; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(posedge clk); force_ack = 1'b1;
    @(posedge clk); force_ack = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    errors = 0; checks = 0; cycles = 0;
    ack_lat = 6; ack_cnt = 0; auto_ack = 1; force_ack = 0;
    model_on = 0; done = 0; ctl_ack = 1'b0;
    hst_valid = 0; hst_write = 0; hst_addr = '0; hst_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // reset state (R1)
    check("R1 reset ctl_req", 64'(ctl_req), 64'd0);
    hread(6'h1C, r); check("R1 reset status", 64'(r), 64'd0);
    hread(6'h00, r); check("R1 reset data hi", 64'(r), 64'd0);

    // R1 data register readback, undecoded offsets
    hwrite(6'h00, 32'h11223344);
    hwrite(6'h04, 32'h55667788);
    hread(6'h00, r); check("R1 data hi readback", 64'(r), 64'h11223344);
    hread(6'h04, r); check("R1 data lo readback", 64'(r), 64'h55667788);
    hwrite(6'h20, 32'hFFFFFFFF);
    hread(6'h20, r); check("R1 offset 0x20 reads zero", 64'(r), 64'd0);
    hread(6'h08, r); check("R1 command reads zero", 64'(r), 64'd0);
    hread(6'h00, r); check("R1 undecoded write ignored", 64'(r), 64'h11223344);

    // R2 write command
    hwrite(6'h08, 32'h80000005);
    check("R2 req raised", 64'(ctl_req), 64'd1);
    check("R2 we", 64'(ctl_we), 64'd1);
    check("R2 offset", 64'(ctl_offset), 64'd5);
    check("R2 wdata", ctl_wdata, 64'h1122334455667788);
    hread(6'h1C, r); check("R4 busy while waiting", 64'(r), 64'h00000001);
    wait_idle();
    hread(6'h1C, r); check("R4 busy cleared", 64'(r), 64'd0);
    hread(6'h00, r); check("R2 data hi kept after write", 64'(r), 64'h11223344);

    // R3 read command
    hwrite(6'h08, 32'h00000007);
    check("R3 req raised for read", 64'(ctl_req), 64'd1);
    check("R3 we low", 64'(ctl_we), 64'd0);
    wait_idle();
    check("R3 req dropped", 64'(ctl_req), 64'd0);
    hread(6'h00, r); check("R3 upper half", 64'(r), 64'hC0FFEE07);
    hread(6'h04, r); check("R3 lower half", 64'(r), 64'h5A5A5AF8);

    // R5 command while busy
    ack_lat = 20;
    hwrite(6'h08, 32'h00000003);
    hwrite(6'h08, 32'h00000004);
    check("R5 offset unchanged", 64'(ctl_offset), 64'd3);
    wait_idle();
    hread(6'h00, r); check("R5 first read completed", 64'(r), 64'hC0FFEE03);
    hread(6'h1C, r); check("R5 error flag", 64'(r), 64'h80000000);
    hwrite(6'h18, 32'd0);
    hread(6'h1C, r); check("R7 reset clears error", 64'(r), 64'd0);

    // R8 data writes while busy
    hwrite(6'h00, 32'h11111111);
    hwrite(6'h04, 32'h22222222);
    hwrite(6'h08, 32'h80000001);
    hwrite(6'h00, 32'h99999999);
    hwrite(6'h04, 32'h88888888);
    check("R8 wdata frozen", ctl_wdata, 64'h1111111122222222);
    wait_idle();
    hread(6'h00, r); check("R8 data hi kept", 64'(r), 64'h11111111);
    hread(6'h04, r); check("R8 data lo kept", 64'(r), 64'h22222222);

    // R6 refused offsets
    ack_lat = 2;
    hwrite(6'h08, 32'h0000000A);
    check("R6 no req at limit", 64'(ctl_req), 64'd0);
    hread(6'h1C, r); check("R6 error at limit", 64'(r), 64'h80000000);
    // R7 sticky across a good transaction
    hwrite(6'h08, 32'h80000009);
    check("R6 last offset accepted", 64'(ctl_req), 64'd1);
    wait_idle();
    hread(6'h1C, r); check("R7 error sticky", 64'(r), 64'h80000000);
    hwrite(6'h18, 32'd0);
    hwrite(6'h08, 32'h00000100);
    check("R6 no req high bits", 64'(ctl_req), 64'd0);
    hread(6'h1C, r); check("R6 error high bits", 64'(r), 64'h80000000);
    hwrite(6'h18, 32'd0);

    // R7 abort pending transaction, late ack
    auto_ack = 0;
    hwrite(6'h00, 32'h0BADF00D);
    hwrite(6'h08, 32'h00000002);
    check("R7 req pending", 64'(ctl_req), 64'd1);
    hwrite(6'h18, 32'd0);
    check("R7 abort drops req", 64'(ctl_req), 64'd0);
    hread(6'h1C, r); check("R7 status after abort", 64'(r), 64'd0);
    pulse_ack();
    hread(6'h00, r); check("R7 late ack ignored", 64'(r), 64'h0BADF00D);

    // R9 ack with no request
    pulse_ack();
    hread(6'h00, r); check("R9 idle ack data hi", 64'(r), 64'h0BADF00D);
    hread(6'h1C, r); check("R9 idle ack status", 64'(r), 64'd0);
    check("R9 idle ack no req", 64'(ctl_req), 64'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule